// File: doc/BRIEF.md
# Reset and Wake-up Sequencer

This block decides when a small microcontroller core runs, when it is held in a full reset and when it only gets a light restart. It watches a power-on reset, an external active-low reset pin, a time-out pulse from the watchdog and a request from the core to enter a low-power halt. It drives a cold system reset to every unit, a one-cycle warm reset to the program counter and stack pointer alone, and a run enable. It also keeps two sticky cause flags, a time-out flag and a power-down flag, that software reads after a restart to learn what happened.

Every restart waits for the oscillator to settle. A start-up counter of `CNT_W` bits (1024 cycles at the default of 10) must run out before the core may run. During a cold restart the counter runs inside the reset period. During a warm wake it runs with the system reset left low. A watchdog time-out while halted is the only event that gives the warm path. Every other reset source gives a cold one.

Top module: `rst_wake_seq`

## Requirements
- R1: While `por_n` is low, `sys_rst` and `sst_busy` are high, `run_en`, `halted` and `warm_rst` are low, and both `flag_to` and `flag_pd` are 0.
- R2: `ext_rst_n` passes through a two-flop synchroniser. A low level seen while running starts a cold reset (`sys_rst` high) and leaves both flags unchanged.
- R3: Once a start-up delay is counting it lasts exactly 2**CNT_W clock cycles with `sst_busy` high. `run_en` rises only when such a delay ends. During a cold delay `sys_rst` stays high throughout.
- R4: While the synchronised pin is low during a delay, the count is held at zero. A pin reset during a delay therefore restarts the full count. After the pin rises, the delay ends 2**CNT_W + 1 cycles later, counted from the first clock edge after the rise.
- R5: `wdt_tmo` while running starts a cold reset, sets `flag_to` to 1 and leaves `flag_pd` unchanged.
- R6: `halt_req` while running (with no pin reset or time-out in the same cycle) enters halt: `halted` high, `run_en` low, `flag_pd`=1, `flag_to`=0.
- R7: A pin reset while halted gives a cold reset with flags (`flag_to`,`flag_pd`) = (0,1).
- R8: `wdt_tmo` while halted gives a warm wake. A delay of 2**CNT_W cycles runs with `sys_rst` low. Then `warm_rst` is high for exactly one cycle, in the first cycle of `run_en`. Flags become (1,1).
- R9: `wdt_clr` while running, with no higher event in that cycle, clears both flags.
- R10: During a delay, `wdt_tmo` and `halt_req` have no effect. A pin reset during a warm delay turns it into a cold reset and leaves the flags unchanged.
- R11: At most one of `sys_rst`, `run_en` and `halted` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (oscillator) |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wdt_tmo | input | 1 | Watchdog time-out pulse |
| halt_req | input | 1 | Core request to enter halt |
| wdt_clr | input | 1 | Software watchdog-clear command |
| sys_rst | output | 1 | Cold system reset to all units (also clears the watchdog) |
| warm_rst | output | 1 | One-cycle reset of program counter and stack pointer |
| run_en | output | 1 | Core may execute |
| halted | output | 1 | Core is in halt |
| sst_busy | output | 1 | Start-up delay is counting |
| flag_to | output | 1 | Time-out cause flag |
| flag_pd | output | 1 | Power-down cause flag |

## Verification
The bench builds the sequencer with `CNT_W` = 4, so each start-up delay is 16 cycles rather than 1024. This makes exact delay lengths cheap to measure for every restart path. It also leaves room for dozens of random chains of events, each of which changes the cause flags in sequence. With the short delay, the bench can put a pin reset inside a running cold or warm delay and pulse the ignored inputs mid-count. These cases would be slow to reach at the default width.

// File: rtl/rws_pkg.sv
package rws_pkg;

  typedef enum logic [1:0] {
    ST_COLD = 2'd0,
    ST_RUN  = 2'd1,
    ST_HALT = 2'd2,
    ST_WARM = 2'd3
  } rws_state_e;

  // true on the last count value of a 2**w cycle delay
  function automatic logic sst_is_last(input logic [31:0] cnt, input int unsigned w);
    logic [31:0] last;
    last = (32'd1 << w) - 32'd1;
    return cnt == last;
  endfunction

endpackage

// File: rtl/rws_pin_sync.sv
module rws_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic pin_n,
  output logic pin_act
);
  logic [STAGES-1:0] shreg;

  // reset to "asserted" so the pin must be seen released before counting
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-2:0], pin_n};
  end

  assign pin_act = ~shreg[STAGES-1];
endmodule

// File: rtl/rws_sst_counter.sv
module rws_sst_counter #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             restart,
  input  logic             advance,
  output logic [CNT_W-1:0] cnt,
  output logic             done
);
  assign done = advance && !restart && rws_pkg::sst_is_last(32'(cnt), CNT_W);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (advance) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rws_flags.sv
module rws_flags (
  input  logic clk,
  input  logic por_n,
  input  logic ev_pin_wake,
  input  logic ev_wdt_cold,
  input  logic ev_wdt_wake,
  input  logic ev_halt,
  input  logic ev_sw_clr,
  output logic flag_to,
  output logic flag_pd
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      flag_to <= 1'b0;
      flag_pd <= 1'b0;
    end else if (ev_pin_wake || ev_halt) begin
      flag_to <= 1'b0;
      flag_pd <= 1'b1;
    end else if (ev_wdt_wake) begin
      flag_to <= 1'b1;
      flag_pd <= 1'b1;
    end else if (ev_wdt_cold) begin
      flag_to <= 1'b1;
    end else if (ev_sw_clr) begin
      flag_to <= 1'b0;
      flag_pd <= 1'b0;
    end
  end
endmodule

// File: rtl/rst_wake_seq.sv
module rst_wake_seq #(
  parameter int unsigned CNT_W     = 10,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic ext_rst_n,
  input  logic wdt_tmo,
  input  logic halt_req,
  input  logic wdt_clr,
  output logic sys_rst,
  output logic warm_rst,
  output logic run_en,
  output logic halted,
  output logic sst_busy,
  output logic flag_to,
  output logic flag_pd
);
  import rws_pkg::*;

  rws_state_e       state, state_n;
  logic             pin_act;
  logic             in_delay, sst_restart, sst_advance, sst_done;
  logic [CNT_W-1:0] sst_cnt;
  logic             warm_q;

  // named events, visible to the checker
  logic ev_pin_cold, ev_pin_wake, ev_pin_warm;
  logic ev_wdt_cold, ev_wdt_wake, ev_halt, ev_sw_clr;

  rws_pin_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk(clk), .por_n(por_n), .pin_n(ext_rst_n), .pin_act(pin_act)
  );

  assign in_delay    = (state == ST_COLD) || (state == ST_WARM);
  assign ev_pin_cold = (state == ST_RUN)  && pin_act;
  assign ev_pin_wake = (state == ST_HALT) && pin_act;
  assign ev_pin_warm = (state == ST_WARM) && pin_act;
  assign ev_wdt_cold = (state == ST_RUN)  && !pin_act && wdt_tmo;
  assign ev_wdt_wake = (state == ST_HALT) && !pin_act && wdt_tmo;
  assign ev_halt     = (state == ST_RUN)  && !pin_act && !wdt_tmo && halt_req;
  assign ev_sw_clr   = (state == ST_RUN)  && !pin_act && !wdt_tmo && !halt_req && wdt_clr;

  assign sst_restart = ev_pin_cold || ev_pin_wake || ev_wdt_cold || ev_wdt_wake
                     || (in_delay && pin_act);
  assign sst_advance = in_delay && !pin_act;

  rws_sst_counter #(.CNT_W(CNT_W)) u_sst (
    .clk(clk), .por_n(por_n), .restart(sst_restart), .advance(sst_advance),
    .cnt(sst_cnt), .done(sst_done)
  );

  rws_flags u_flags (
    .clk(clk), .por_n(por_n),
    .ev_pin_wake(ev_pin_wake), .ev_wdt_cold(ev_wdt_cold), .ev_wdt_wake(ev_wdt_wake),
    .ev_halt(ev_halt), .ev_sw_clr(ev_sw_clr),
    .flag_to(flag_to), .flag_pd(flag_pd)
  );

  always_comb begin
    state_n = state;
    unique case (state)
      ST_COLD: if (sst_done) state_n = ST_RUN;
      ST_WARM: begin
        if (ev_pin_warm)   state_n = ST_COLD;
        else if (sst_done) state_n = ST_RUN;
      end
      ST_RUN: begin
        if (ev_pin_cold || ev_wdt_cold) state_n = ST_COLD;
        else if (ev_halt)               state_n = ST_HALT;
      end
      ST_HALT: begin
        if (ev_pin_wake)      state_n = ST_COLD;
        else if (ev_wdt_wake) state_n = ST_WARM;
      end
      default: state_n = ST_COLD;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state  <= ST_COLD;
      warm_q <= 1'b0;
    end else begin
      state  <= state_n;
      warm_q <= (state == ST_WARM) && sst_done;
    end
  end

  assign sys_rst  = (state == ST_COLD);
  assign run_en   = (state == ST_RUN);
  assign halted   = (state == ST_HALT);
  assign sst_busy = in_delay;
  assign warm_rst = warm_q;
endmodule

// File: rtl/rws_checker.sv
module rws_checker #(
  parameter int unsigned CNT_W = 10
) (
  input logic             clk,
  input logic             por_n,
  input logic             sys_rst,
  input logic             warm_rst,
  input logic             run_en,
  input logic             halted,
  input logic             sst_busy,
  input logic             flag_to,
  input logic             flag_pd,
  input logic             pin_act,
  input logic             ev_wdt_wake,
  input logic             ev_halt,
  input logic [CNT_W-1:0] sst_cnt
);
  assert_exclusive_R11: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0({sys_rst, run_en, halted}));

  assert_run_after_delay_R3: assert property (@(posedge clk) disable iff (!por_n)
    $rose(run_en) |-> $past(sst_busy));

  assert_pin_holds_count_R4: assert property (@(posedge clk) disable iff (!por_n)
    (sst_busy && pin_act) |=> (sst_cnt == '0));

  assert_halt_entry_R6: assert property (@(posedge clk) disable iff (!por_n)
    ev_halt |=> (halted && flag_pd && !flag_to));

  assert_wdt_wake_warm_R8: assert property (@(posedge clk) disable iff (!por_n)
    ev_wdt_wake |=> (flag_to && flag_pd && sst_busy && !sys_rst));

  assert_warm_pulse_R8: assert property (@(posedge clk) disable iff (!por_n)
    warm_rst |-> (run_en && $past(sst_busy) && !$past(sys_rst)));

  assert_warm_single_R8: assert property (@(posedge clk) disable iff (!por_n)
    warm_rst |=> !warm_rst);
endmodule

bind rst_wake_seq rws_checker #(.CNT_W(CNT_W)) u_rws_checker (
  .clk(clk), .por_n(por_n), .sys_rst(sys_rst), .warm_rst(warm_rst),
  .run_en(run_en), .halted(halted), .sst_busy(sst_busy),
  .flag_to(flag_to), .flag_pd(flag_pd), .pin_act(pin_act),
  .ev_wdt_wake(ev_wdt_wake), .ev_halt(ev_halt), .sst_cnt(sst_cnt)
);

// File: tb/test_rst_wake_seq.sv
module test_rst_wake_seq;
  localparam int unsigned W   = 4;
  localparam int          DLY = 1 << W;

  logic clk = 1'b0;
  logic por_n = 1'b0, ext_rst_n = 1'b1, wdt_tmo = 1'b0, halt_req = 1'b0, wdt_clr = 1'b0;
  logic sys_rst, warm_rst, run_en, halted, sst_busy, flag_to, flag_pd;

  int n_chk = 0, n_bad = 0;
  bit to_m = 1'b0, pd_m = 1'b0;

  always #10 clk = ~clk;

  rst_wake_seq #(.CNT_W(W)) i_rst_wake_seq (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .wdt_tmo(wdt_tmo),
    .halt_req(halt_req), .wdt_clr(wdt_clr), .sys_rst(sys_rst), .warm_rst(warm_rst),
    .run_en(run_en), .halted(halted), .sst_busy(sst_busy),
    .flag_to(flag_to), .flag_pd(flag_pd)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected cycles of sst_busy after the restart stimulus
  function automatic int exp_len(input bit via_pin);
    return via_pin ? DLY + 1 : DLY;
  endfunction

  // flag model: op 0 pin@run, 1 wdt@run, 2 pin@halt, 3 wdt@halt, 4 clear, 5 halt
  function automatic bit [1:0] next_flags(input int op, input bit t, input bit p);
    case (op)
      1: return {1'b1, p};
      2: return 2'b01;
      3: return 2'b11;
      4: return 2'b00;
      5: return 2'b01;
      default: return {t, p};
    endcase
  endfunction

  // count busy samples; pulses are dropped at the first sample
  task automatic count_busy(input bit noise, output int n, output bit saw_sys, output bit saw_warm);
    n = 0; saw_sys = 1'b0; saw_warm = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      wdt_tmo = 1'b0; halt_req = 1'b0; wdt_clr = 1'b0;
      if (!sst_busy) break;
      n++;
      if (sys_rst) saw_sys = 1'b1;
      if (noise && n == 3) begin wdt_tmo = 1'b1; halt_req = 1'b1; end
    end
    saw_warm = warm_rst;
  endtask

  task automatic flags_are(input string req);
    chk({req, " flag_to"}, int'(flag_to), int'(to_m));
    chk({req, " flag_pd"}, int'(flag_pd), int'(pd_m));
  endtask

  task automatic do_pin(input string req);
    int n; bit s, wm;
    @(negedge clk); ext_rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk({req, " sys_rst during pin"}, int'(sys_rst), 1);
    ext_rst_n = 1'b1;
    count_busy(1'b0, n, s, wm);
    chk({req, " delay length"}, n, exp_len(1'b1));
    chk({req, " run_en after delay"}, int'(run_en), 1);
  endtask

  task automatic do_wdt_run(input bit noise);
    int n; bit s, wm;
    @(negedge clk); wdt_tmo = 1'b1;
    count_busy(noise, n, s, wm);
    chk("R3 R5 cold delay length", n, exp_len(1'b0));
    chk("R3 sys_rst held through delay", int'(s), 1);
  endtask

  task automatic do_halt();
    @(negedge clk); halt_req = 1'b1;
    @(negedge clk); halt_req = 1'b0;
    chk("R6 halted", int'(halted), 1);
    chk("R6 run_en low", int'(run_en), 0);
  endtask

  task automatic do_wdt_halt(input bit noise);
    int n; bit s, wm;
    @(negedge clk); wdt_tmo = 1'b1;
    count_busy(noise, n, s, wm);
    chk("R8 warm delay length", n, exp_len(1'b0));
    chk("R8 no sys_rst on warm wake", int'(s), 0);
    chk("R8 warm_rst pulse", int'(wm), 1);
    @(negedge clk);
    chk("R8 warm_rst single cycle", int'(warm_rst), 0);
  endtask

  task automatic apply(input int op);
    bit [1:0] f;
    case (op)
      0: do_pin("R2");
      1: do_wdt_run(1'b0);
      2: begin do_halt(); f = next_flags(5, to_m, pd_m); {to_m, pd_m} = f; do_pin("R7"); end
      3: begin do_halt(); f = next_flags(5, to_m, pd_m); {to_m, pd_m} = f; do_wdt_halt(1'b0); end
      default: begin @(negedge clk); wdt_clr = 1'b1; @(negedge clk); wdt_clr = 1'b0; end
    endcase
    f = next_flags(op, to_m, pd_m);
    {to_m, pd_m} = f;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n; bit s, wm;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 sys_rst", int'(sys_rst), 1);
    chk("R1 sst_busy", int'(sst_busy), 1);
    chk("R1 run_en", int'(run_en), 0);
    chk("R1 halted", int'(halted), 0);
    chk("R1 warm_rst", int'(warm_rst), 0);
    flags_are("R1");
    por_n = 1'b1;
    count_busy(1'b0, n, s, wm);
    chk("R3 R4 power-up delay", n, exp_len(1'b1));
    chk("R3 run_en after power-up", int'(run_en), 1);

    // R5 then R2: flags (1,0) kept by pin reset
    apply(1); flags_are("R5");
    apply(0); flags_are("R2");
    // R9 clear
    apply(4); flags_are("R9");
    // R6 halt entry flags
    apply(1);
    do_halt(); to_m = 1'b0; pd_m = 1'b1; flags_are("R6");
    // R10 halt_req while halted ignored
    @(negedge clk); halt_req = 1'b1; @(negedge clk); halt_req = 1'b0;
    chk("R10 still halted", int'(halted), 1);
    // R8 warm wake with ignored pulses mid-delay (R10)
    do_wdt_halt(1'b1); to_m = 1'b1; pd_m = 1'b1; flags_are("R8 R10");
    // R7 pin wake
    apply(2); flags_are("R7");
    // R10 pulses during a cold delay ignored
    do_wdt_run(1'b1); to_m = 1'b1; flags_are("R10 cold");

    // R4 pin during cold delay restarts count
    @(negedge clk); wdt_tmo = 1'b1; @(negedge clk); wdt_tmo = 1'b0;
    repeat (5) @(negedge clk);
    ext_rst_n = 1'b0; repeat (4) @(negedge clk); ext_rst_n = 1'b1;
    count_busy(1'b0, n, s, wm);
    chk("R4 restart full count", n, exp_len(1'b1));

    // R10 pin during warm delay -> cold, flags kept
    do_halt(); to_m = 1'b0; pd_m = 1'b1;
    @(negedge clk); wdt_tmo = 1'b1; @(negedge clk); wdt_tmo = 1'b0;
    to_m = 1'b1;
    repeat (3) @(negedge clk);
    ext_rst_n = 1'b0; repeat (4) @(negedge clk);
    chk("R10 warm turned cold", int'(sys_rst), 1);
    ext_rst_n = 1'b1;
    count_busy(1'b0, n, s, wm);
    chk("R10 R4 delay after warm abort", n, exp_len(1'b1));
    chk("R10 no warm_rst", int'(wm), 0);
    flags_are("R10 warm abort");

    // random chains of events
    for (int k = 0; k < 30; k++) begin
      int op;
      op = int'($urandom_range(0, 4));
      apply(op);
      flags_are("R2 R5 R7 R8 R9 random");
      chk("R11 running only", int'({sys_rst, run_en, halted}), 3'b010);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule